// File: doc/BRIEF.md
# Banked Chip-Select Wait-State Controller

This block sits between a processor's internal bus and a set of SRAM-style external devices. It holds eight bank descriptors. Each descriptor has a valid bit, a base address, a power-of-two block size, a port width, a wait-state count and a write-protect bit. When a request arrives, the address is compared against every valid bank. The first matching bank then receives a chip-select for a number of clocks set by its wait count. During that window the output-enable (for reads) or the byte write-enables (for writes) are driven alongside the chip-select. The access ends with a one-cycle acknowledge.

Bank 0 is live straight out of reset so that code can be fetched before any descriptor is written. It spans the whole address space, uses the maximum boot wait count, and takes its port width from a strap input sampled during reset.

The requester holds off further requests until it sees an acknowledge or an error. A request that matches no bank produces no response at all. An external bus monitor is expected to time that request out.

Top module: `cs_wait_ctrl`

## Requirements
- R1: During and right after reset, every chip-select, the output-enable and all write-enables are high (inactive), and ack and err are low. Bank 0 is then valid with base 0 and covers the whole address space. Its port width is taken from `bootWidth` as sampled during reset, and its wait count is BOOT_WAIT (default 15). All other banks are invalid.
- R2: A bank with size code s covers 2^(15+s) bytes, starting at its base with the low 15+s address bits ignored. Size codes reaching past the address width cover everything. An address just past a block's end does not match it.
- R3: When several valid banks match, the lowest-numbered one is selected.
- R4: For a request sampled at clock edge E with a bank of wait count W, that bank's chip-select is low for the W+1 cycles after E, and ack pulses for one cycle in the last of them. With W=0, the access therefore takes two clocks counting the request cycle.
- R5: A programmed wait count above 30 is stored as 30.
- R6: During a read, `oeN` is low for the whole chip-select window and `weN` stays 4'hF. During a write, `oeN` stays high.
- R7: Write lanes (bit i means byte offset i within a word) depend on port width (`cfgWidth`/`bootWidth`: 0=8-bit, 1=16-bit, 2 or 3=32-bit) and size (`reqSize`: 0=byte, 1=half, 2 or 3=word). An 8-bit port always uses 0001. A 16-bit port uses 0001 or 0010 for bytes by `reqAddr[0]`, and 0011 otherwise. A 32-bit port uses 1<<`reqAddr[1:0]` for bytes, 0011 or 1100 for halves by `reqAddr[1]`, and 1111 for words. Each selected lane drives its `weN` bit low for the whole window.
- R8: A write to a write-protected bank still drives its chip-select for W+1 cycles but drives no write-enable, and it ends with err instead of ack. A read of a protected bank completes normally with ack.
- R9: A request matching no valid bank drives no strobe, ack or err, and the block accepts the next request at once.
- R10: Requests presented while an access is in progress are ignored. The ongoing access keeps its bank and timing, and no further access follows.
- R11: A cycle with `cfgWe` high loads all fields of bank `cfgBank` (valid, base, size code, width, wait, write-protect). Clearing valid removes the bank from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bootWidth | input | 2 | Boot bank port width strap, sampled while in reset |
| cfgWe | input | 1 | Load one bank descriptor |
| cfgBank | input | 3 | Descriptor index to load |
| cfgValid | input | 1 | New valid bit |
| cfgBase | input | 26 | New base address |
| cfgSize | input | 4 | New size code (block = 2^(15+code) bytes) |
| cfgWidth | input | 2 | New port width code |
| cfgWait | input | 5 | New wait-state count (saturates at 30) |
| cfgWp | input | 1 | New write-protect bit |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 26 | Byte address of the access |
| reqSize | input | 2 | Transfer size code |
| csN | output | 8 | Per-bank chip-selects, active low |
| oeN | output | 1 | Shared output-enable, active low |
| weN | output | 4 | Byte-lane write-enables, active low |
| ack | output | 1 | Access completed |
| err | output | 1 | Write to protected bank refused |

## Verification
The embedded assertions check the following on every cycle: at most one chip-select is low, output-enable and write-enables never overlap, ack and err never coincide, and an error cycle carries no write strobe. They also check that the wait counter never exceeds 30, that each access finishes with exactly one terminal pulse, that the countdown steps by one, and that the latched bank holds steady mid-access. Only the directed scenarios can show the cases that need expected values: which bank wins an overlap, where a block ends, the exact lane pattern for each width and size, the cycle on which ack lands for a given wait count, the boot descriptor taken from the strap, and the silence after an unmatched request.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int WAIT_W   = 5;
  localparam int WAIT_MAX = 30;
  localparam int SIZE_W   = 4;

  typedef enum logic [1:0] {
    PW8   = 2'd0,
    PW16  = 2'd1,
    PW32  = 2'd2,
    PW32X = 2'd3
  } portWidth_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORDX = 2'd3
  } xferSize_t;

  typedef struct packed {
    logic                valid;
    logic [SIZE_W-1:0]   sizeCode;
    portWidth_t          width;
    logic [WAIT_W-1:0]   waitCnt;
    logic                wp;
  } bankAttr_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // latch the selected bank and lanes
    logic drive;    // access window open
    logic finish;   // last cycle of the window
  } ctrlStrobe_t;

  function automatic logic [3:0] laneMask(portWidth_t w, xferSize_t s, logic [1:0] a);
    logic [3:0] m;
    unique case (w)
      PW8:  m = 4'b0001;
      PW16: m = (s == SZ_BYTE) ? (a[0] ? 4'b0010 : 4'b0001) : 4'b0011;
      default: begin
        unique case (s)
          SZ_BYTE: m = 4'b0001 << a;
          SZ_HALF: m = a[1] ? 4'b1100 : 4'b0011;
          default: m = 4'b1111;
        endcase
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cs_bank_file.sv
module cs_bank_file
  import cs_pkg::*;
#(
  parameter int AW        = 26,
  parameter int NB        = 8,
  parameter int BW        = $clog2(NB),
  parameter int MIN_LOG   = 15,
  parameter int BOOT_WAIT = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         bootWidth,
  input  logic               cfgWe,
  input  logic [BW-1:0]      cfgBank,
  input  logic               cfgValid,
  input  logic [AW-1:0]      cfgBase,
  input  logic [SIZE_W-1:0]  cfgSize,
  input  logic [1:0]         cfgWidth,
  input  logic [WAIT_W-1:0]  cfgWait,
  input  logic               cfgWp,
  input  logic [AW-1:0]      lookAddr,
  output logic               hit,
  output logic [BW-1:0]      hitIdx,
  output logic [1:0]         hitWidth,
  output logic [WAIT_W-1:0]  hitWait,
  output logic               hitWp
);

  localparam logic [SIZE_W-1:0] BOOT_SIZE = SIZE_W'(AW - MIN_LOG);
  localparam logic [WAIT_W-1:0] BOOT_WT   = WAIT_W'(BOOT_WAIT);
  localparam logic [WAIT_W-1:0] WT_LIMIT  = WAIT_W'(WAIT_MAX);

  bankAttr_t         attr [NB];
  logic [AW-1:0]     base [NB];
  logic [WAIT_W-1:0] cfgWaitSat;
  logic [NB-1:0]     hitVec;

  assign cfgWaitSat = (cfgWait > WT_LIMIT) ? WT_LIMIT : cfgWait;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NB; i++) begin
        attr[i] <= '0;
        base[i] <= '0;
      end
      attr[0].valid    <= 1'b1;
      attr[0].sizeCode <= BOOT_SIZE;
      attr[0].width    <= portWidth_t'(bootWidth);
      attr[0].waitCnt  <= BOOT_WT;
    end else if (cfgWe) begin
      attr[cfgBank].valid    <= cfgValid;
      attr[cfgBank].sizeCode <= cfgSize;
      attr[cfgBank].width    <= portWidth_t'(cfgWidth);
      attr[cfgBank].waitCnt  <= cfgWaitSat;
      attr[cfgBank].wp       <= cfgWp;
      base[cfgBank]          <= cfgBase;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_match
    logic [AW-1:0] keep;
    always_comb begin
      for (int j = 0; j < AW; j++)
        keep[j] = (j >= MIN_LOG + int'(attr[g].sizeCode));
    end
    assign hitVec[g] = attr[g].valid && (((lookAddr ^ base[g]) & keep) == '0);
  end

  always_comb begin
    hit    = |hitVec;
    hitIdx = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (hitVec[i]) hitIdx = BW'(i);
    hitWidth = attr[hitIdx].width;
    hitWait  = attr[hitIdx].waitCnt;
    hitWp    = attr[hitIdx].wp;
  end

  // R5: stored wait counts never exceed the limit
  a_r5_stored_wait: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (hitWait <= WT_LIMIT));

  // R3: no lower-numbered bank also matches the chosen one
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (hitVec[hitIdx] && ((hitVec & ((NB'(1) << hitIdx) - NB'(1))) == '0)));

endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              hit,
  input  logic [WAIT_W-1:0] hitWait,
  output ctrlStrobe_t       strobe
);

  logic              busyQ;
  logic [WAIT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (!busyQ) begin
      if (reqValid && hit) begin
        busyQ <= 1'b1;
        cntQ  <= hitWait;
      end
    end else if (cntQ == '0) begin
      busyQ <= 1'b0;
    end else begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign strobe.capture = !busyQ && reqValid && hit;
  assign strobe.drive   = busyQ;
  assign strobe.finish  = busyQ && (cntQ == '0);

  // R5: the countdown stays within the wait limit
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= WAIT_W'(WAIT_MAX));

  // R4: the window closes right after its final cycle
  a_r4_single_finish: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !strobe.drive);

  // R4: one wait state consumed per clock
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && cntQ != '0) |=> (busyQ && cntQ == $past(cntQ) - 1'b1));

endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import cs_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [1:0]    reqAddrLo,
  input  logic          reqWrite,
  input  logic [1:0]    reqSize,
  input  logic [BW-1:0] hitIdx,
  input  logic [1:0]    hitWidth,
  input  logic          hitWp,
  output logic [NB-1:0] csN,
  output logic          oeN,
  output logic [3:0]    weN,
  output logic          ack,
  output logic          err
);

  logic [BW-1:0] selBank;
  logic [3:0]    selLanes;
  logic          selWrite;
  logic          selWp;
  logic          blocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selBank  <= '0;
      selLanes <= '0;
      selWrite <= 1'b0;
      selWp    <= 1'b0;
    end else if (strobe.capture) begin
      selBank  <= hitIdx;
      selLanes <= laneMask(portWidth_t'(hitWidth), xferSize_t'(reqSize), reqAddrLo);
      selWrite <= reqWrite;
      selWp    <= hitWp;
    end
  end

  assign blocked = selWrite && selWp;

  always_comb begin
    csN = '1;
    if (strobe.drive) csN[selBank] = 1'b0;
  end

  assign oeN = !(strobe.drive && !selWrite);
  assign weN = (strobe.drive && selWrite && !selWp) ? ~selLanes : 4'hF;
  assign ack = strobe.finish && !blocked;
  assign err = strobe.finish && blocked;

  // R4: one bank selected at a time
  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R6: read and write strobes never overlap
  a_r6_oe_we_excl: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (weN == 4'hF));

  // R8: refused write carries no write strobe and no ack
  a_r8_err_clean: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (weN == 4'hF && !ack));

  // R10: latched access does not change mid-window
  a_r10_hold_sel: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drive && !strobe.finish) |=> ($stable(selBank) && $stable(selWrite) && $stable(selLanes)));

endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
  import cs_pkg::*;
#(
  parameter int AW        = 26,
  parameter int NB        = 8,
  parameter int BW        = $clog2(NB),
  parameter int MIN_LOG   = 15,
  parameter int BOOT_WAIT = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         bootWidth,
  input  logic               cfgWe,
  input  logic [BW-1:0]      cfgBank,
  input  logic               cfgValid,
  input  logic [AW-1:0]      cfgBase,
  input  logic [SIZE_W-1:0]  cfgSize,
  input  logic [1:0]         cfgWidth,
  input  logic [WAIT_W-1:0]  cfgWait,
  input  logic               cfgWp,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [AW-1:0]      reqAddr,
  input  logic [1:0]         reqSize,
  output logic [NB-1:0]      csN,
  output logic               oeN,
  output logic [3:0]         weN,
  output logic               ack,
  output logic               err
);

  logic              hit;
  logic [BW-1:0]     hitIdx;
  logic [1:0]        hitWidth;
  logic [WAIT_W-1:0] hitWait;
  logic              hitWp;
  ctrlStrobe_t       strobe;

  cs_bank_file #(.AW(AW), .NB(NB), .BW(BW), .MIN_LOG(MIN_LOG), .BOOT_WAIT(BOOT_WAIT)) uBanks (
    .clk(clk), .rstN(rstN), .bootWidth(bootWidth),
    .cfgWe(cfgWe), .cfgBank(cfgBank), .cfgValid(cfgValid), .cfgBase(cfgBase),
    .cfgSize(cfgSize), .cfgWidth(cfgWidth), .cfgWait(cfgWait), .cfgWp(cfgWp),
    .lookAddr(reqAddr), .hit(hit), .hitIdx(hitIdx),
    .hitWidth(hitWidth), .hitWait(hitWait), .hitWp(hitWp)
  );

  cs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .hitWait(hitWait), .strobe(strobe)
  );

  cs_datapath #(.NB(NB), .BW(BW)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddrLo(reqAddr[1:0]), .reqWrite(reqWrite), .reqSize(reqSize),
    .hitIdx(hitIdx), .hitWidth(hitWidth), .hitWp(hitWp),
    .csN(csN), .oeN(oeN), .weN(weN), .ack(ack), .err(err)
  );

endmodule

// File: tb/cs_wait_ctrl_test.sv
`timescale 1ns/1ps
module cs_wait_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  bootWidth;
  logic        cfgWe;
  logic [2:0]  cfgBank;
  logic        cfgValid;
  logic [25:0] cfgBase;
  logic [3:0]  cfgSize;
  logic [1:0]  cfgWidth;
  logic [4:0]  cfgWait;
  logic        cfgWp;
  logic        reqValid;
  logic        reqWrite;
  logic [25:0] reqAddr;
  logic [1:0]  reqSize;
  logic [7:0]  csN;
  logic        oeN;
  logic [3:0]  weN;
  logic        ack;
  logic        err;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  cs_wait_ctrl uut (
    .clk(clk), .rstN(rstN), .bootWidth(bootWidth),
    .cfgWe(cfgWe), .cfgBank(cfgBank), .cfgValid(cfgValid), .cfgBase(cfgBase),
    .cfgSize(cfgSize), .cfgWidth(cfgWidth), .cfgWait(cfgWait), .cfgWp(cfgWp),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .csN(csN), .oeN(oeN), .weN(weN), .ack(ack), .err(err)
  );

  task automatic checkIdle(input string tag, input string what);
    testsRun++;
    if (csN !== 8'hFF || oeN !== 1'b1 || weN !== 4'hF || ack !== 1'b0 || err !== 1'b0) begin
      testsFailed++;
      $display("FAIL %s %s: cs=%b oe=%b we=%b ack=%b err=%b expected cs=11111111 oe=1 we=1111 ack=0 err=0",
               tag, what, csN, oeN, weN, ack, err);
    end
  endtask

  task automatic setBank(input int bank, input bit valid, input logic [25:0] base,
                         input int size, input int width, input int waits, input bit wp);
    @(negedge clk);
    cfgWe = 1'b1; cfgBank = 3'(bank); cfgValid = valid; cfgBase = base;
    cfgSize = 4'(size); cfgWidth = 2'(width); cfgWait = 5'(waits); cfgWp = wp;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one full access, checked on every cycle of the window and the cycle after
  task automatic runAccess(input string tag, input logic [25:0] addr, input bit wr,
                           input int sz, input int bank, input int waits,
                           input bit expErr, input logic [3:0] lanes);
    logic [7:0] expCs;
    logic [3:0] expWe;
    bit bad;
    expCs = ~(8'd1 << bank);
    expWe = (wr && !expErr) ? ~lanes : 4'hF;
    bad = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = wr; reqSize = 2'(sz);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 1; k <= waits + 1; k++) begin
      bit last;
      if (k > 1) @(negedge clk);
      last = (k == waits + 1);
      if (!bad && (csN !== expCs || oeN !== wr || weN !== expWe ||
                   ack !== (last && !expErr) || err !== (last && expErr))) begin
        bad = 1'b1;
        $display("FAIL %s addr=%h cycle %0d: cs=%b oe=%b we=%b ack=%b err=%b expected cs=%b oe=%b we=%b ack=%b err=%b",
                 tag, addr, k, csN, oeN, weN, ack, err, expCs, wr, expWe,
                 last && !expErr, last && expErr);
      end
    end
    testsRun++;
    if (bad) testsFailed++;
    @(negedge clk);
    checkIdle(tag, "after access");
  endtask

  task automatic runMiss(input string tag, input logic [25:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWrite = 1'b0; reqSize = 2'd2;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      checkIdle(tag, "unmatched request");
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    checkIdle("R1", "after reset");
  endtask

  task automatic testBoot();
    // bootWidth was 0 (8-bit) during reset; boot wait 15
    runAccess("R1 boot read", 26'h000100, 1'b0, 2, 0, 15, 1'b0, 4'b0000);
    runAccess("R1 R7 boot byte write", 26'h000003, 1'b1, 0, 0, 15, 1'b0, 4'b0001);
    runAccess("R1 R7 boot word write", 26'h000000, 1'b1, 2, 0, 15, 1'b0, 4'b0001);
    // R11: shrink bank 0 to 32K, 32-bit, 1 wait
    setBank(0, 1'b1, 26'h000000, 0, 2, 1, 1'b0);
    runAccess("R11 R7 bank0 reprogrammed", 26'h000003, 1'b1, 0, 0, 1, 1'b0, 4'b1000);
  endtask

  task automatic testMatchPriority();
    setBank(1, 1'b1, 26'h010000, 1, 2, 0, 1'b0);
    setBank(2, 1'b1, 26'h010000, 0, 0, 4, 1'b0);
    setBank(3, 1'b1, 26'h020000, 0, 2, 1, 1'b0);
    setBank(4, 1'b1, 26'h020000, 2, 2, 2, 1'b0);
    runAccess("R3 R4 overlap bank1 zero wait", 26'h010100, 1'b0, 2, 1, 0, 1'b0, 4'b0000);
    runAccess("R2 bank1 upper half", 26'h018000, 1'b0, 2, 1, 0, 1'b0, 4'b0000);
    runAccess("R3 overlap bank3", 26'h021000, 1'b0, 2, 3, 1, 1'b0, 4'b0000);
    runAccess("R2 bank4 only", 26'h030000, 1'b0, 2, 4, 2, 1'b0, 4'b0000);
    runAccess("R2 bank4 last word", 26'h03FFFC, 1'b0, 2, 4, 2, 1'b0, 4'b0000);
    runMiss("R2 just past bank4", 26'h040000);
  endtask

  task automatic testWaitClamp();
    setBank(5, 1'b1, 26'h100000, 0, 2, 31, 1'b0);
    runAccess("R5 wait 31 clamps to 30", 26'h100010, 1'b0, 2, 5, 30, 1'b0, 4'b0000);
  endtask

  task automatic testLanes();
    runAccess("R7 w32 byte off2", 26'h010002, 1'b1, 0, 1, 0, 1'b0, 4'b0100);
    runAccess("R7 w32 byte off1", 26'h010001, 1'b1, 0, 1, 0, 1'b0, 4'b0010);
    runAccess("R7 w32 half high", 26'h010002, 1'b1, 1, 1, 0, 1'b0, 4'b1100);
    runAccess("R7 w32 half low", 26'h010000, 1'b1, 1, 1, 0, 1'b0, 4'b0011);
    runAccess("R7 w32 word", 26'h010000, 1'b1, 2, 1, 0, 1'b0, 4'b1111);
    setBank(6, 1'b1, 26'h200000, 0, 1, 2, 1'b0);
    runAccess("R7 w16 byte odd", 26'h200001, 1'b1, 0, 6, 2, 1'b0, 4'b0010);
    runAccess("R7 w16 byte even", 26'h200000, 1'b1, 0, 6, 2, 1'b0, 4'b0001);
    runAccess("R7 w16 word", 26'h200000, 1'b1, 2, 6, 2, 1'b0, 4'b0011);
    runAccess("R6 w16 read", 26'h200004, 1'b0, 2, 6, 2, 1'b0, 4'b0000);
  endtask

  task automatic testProtect();
    setBank(7, 1'b1, 26'h300000, 0, 2, 3, 1'b1);
    runAccess("R8 protected write", 26'h300000, 1'b1, 2, 7, 3, 1'b1, 4'b1111);
    runAccess("R8 protected read", 26'h300000, 1'b0, 2, 7, 3, 1'b0, 4'b0000);
  endtask

  task automatic testMiss();
    runMiss("R9 no bank", 26'h3F0000);
    // accepted straight after the miss
    runAccess("R9 ready after miss", 26'h010000, 1'b0, 2, 1, 0, 1'b0, 4'b0000);
  endtask

  task automatic testIgnore();
    bit bad;
    bad = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 26'h200000; reqWrite = 1'b0; reqSize = 2'd2;
    @(negedge clk);
    reqAddr = 26'h010000;  // second request held during window cycle 1
    if (csN !== 8'hBF || ack !== 1'b0) bad = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (csN !== 8'hBF || ack !== 1'b0) bad = 1'b1;
    @(negedge clk);
    if (csN !== 8'hBF || ack !== 1'b1) bad = 1'b1;
    testsRun++;
    if (bad) begin
      testsFailed++;
      $display("FAIL R10 in-flight request disturbed access: cs=%b ack=%b expected cs=10111111 ack=1",
               csN, ack);
    end
    @(negedge clk);
    checkIdle("R10", "no access from ignored request");
  endtask

  task automatic testDisable();
    setBank(1, 1'b0, 26'h010000, 1, 2, 0, 1'b0);
    runAccess("R11 disabled bank1 falls to bank2", 26'h012345, 1'b0, 2, 2, 4, 1'b0, 4'b0000);
    runMiss("R11 disabled bank1 region", 26'h018000);
  endtask

  initial begin
    rstN = 1'b0; bootWidth = 2'd0;
    cfgWe = 1'b0; cfgBank = '0; cfgValid = 1'b0; cfgBase = '0; cfgSize = '0;
    cfgWidth = '0; cfgWait = '0; cfgWp = 1'b0;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqSize = '0;
    repeat (4) @(negedge clk);
    checkIdle("R1", "during reset");
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBoot();
    testMatchPriority();
    testWaitClamp();
    testLanes();
    testProtect();
    testMiss();
    testIgnore();
    testDisable();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1000000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule